// File: doc/BRIEF.md
# Add-with-Carry Flag Unit with Condition Evaluator

This block is the arithmetic-flag core of an integer datapath. A parameterised adder sums two operands and a carry-in. Alongside the sum it produces a four-bit flag vector: negative, zero, carry and overflow. Carry and overflow are defined against the exact sum that an adder of unlimited width would produce. Subtraction uses the same adder: the caller inverts the second operand and drives the carry-in high.

A flag register captures the adder's flags on any clock edge where the flag-write enable is high. A condition evaluator reads the registered flags and a four-bit condition code, and reports whether the condition passes. In the condition code:

- The upper three bits choose one of eight base tests.
- The lowest bit inverts the chosen test.
- Code 1111 always passes.

The evaluator never sees the adder flags of the current cycle. An instruction that computes new flags therefore cannot steer its own condition.

Top module: `addc_cond_unit`

## Requirements
- R1: `sum` equals (op_a + op_b + carry_in) modulo 2^WIDTH, combinationally.
- R2: In `flags_now`, N equals sum[WIDTH-1], and Z is 1 exactly when every bit of `sum` is 0.
- R3: C in `flags_now` is 1 exactly when the unsigned value of op_a + op_b + carry_in, computed without truncation, is 2^WIDTH or more.
- R4: V in `flags_now` is 1 exactly when the two's-complement sum of op_a, op_b and carry_in, computed without truncation, lies outside the signed WIDTH-bit range.
- R5: Both flag outputs pack the bits as N at bit 3, Z at bit 2, C at bit 1 and V at bit 0.
- R6: On a rising clock edge with flag_we = 1 and rst = 0, `flags_q` takes the value of `flags_now`. On edges with flag_we = 0 it keeps its value.
- R7: A rising edge with rst = 1 clears `flags_q` to 0000, whatever flag_we is.
- R8: cond_code[3:1] selects the base test against `flags_q`:
  - 000: Z
  - 001: C
  - 010: N
  - 011: V
  - 100: C and not Z
  - 101: N equal to V
  - 110: N equal to V and not Z
  - 111: true
- R9: With cond_code[0] = 1 the base result is inverted, except that code 1111 passes like 1110.
- R10: `cond_pass` depends only on `cond_code` and `flags_q`. Operand changes without a flag write leave it unchanged.
- R11: With op_b inverted and carry_in = 1, `sum` equals op_a - op_b modulo 2^WIDTH, and C is 1 exactly when op_a >= op_b taken as unsigned values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | WIDTH | First addend |
| op_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| flag_we | input | 1 | Load `flags_now` into the flag register on the next edge |
| cond_code | input | 4 | Condition to evaluate |
| sum | output | WIDTH | Truncated sum |
| flags_now | output | 4 | Adder flags of the current operands, N Z C V |
| flags_q | output | 4 | Registered flags, N Z C V |
| cond_pass | output | 1 | Condition result against `flags_q` |

## Verification
The bench builds the unit with WIDTH = 8. At that width every operand pair with both carry-in values can be applied, so all carry and overflow boundaries are reached:

- 0x7F + 1
- 0x80 + 0x80
- 0xFF + 1
- 0xFF + 0xFF + 1

The narrow width also lets the bench search operands for each flag state the adder can reach. It loads each such state into the register and sweeps all sixteen condition codes against it. Flag states in which N and Z are both set cannot be produced, and neither can Z with V and no carry. Those states are left out.

// File: rtl/addc_pkg.sv
package addc_pkg;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef enum logic [2:0] {
        BT_ZERO     = 3'b000,
        BT_CARRY    = 3'b001,
        BT_NEG      = 3'b010,
        BT_OVF      = 3'b011,
        BT_UHIGHER  = 3'b100,
        BT_SGE      = 3'b101,
        BT_SGT      = 3'b110,
        BT_ALWAYS   = 3'b111
    } base_test_e;

    localparam logic [3:0] COND_ALWAYS_ALT = 4'b1111;

    function automatic logic base_eval(input base_test_e sel, input flags_t f);
        logic r;
        case (sel)
            BT_ZERO:    r = f.z;
            BT_CARRY:   r = f.c;
            BT_NEG:     r = f.n;
            BT_OVF:     r = f.v;
            BT_UHIGHER: r = f.c & ~f.z;
            BT_SGE:     r = (f.n == f.v);
            BT_SGT:     r = (f.n == f.v) & ~f.z;
            default:    r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/addc_adder.sv
module addc_adder
    import addc_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output flags_t           flags
);
    localparam int XW = WIDTH + 1;

    logic [XW-1:0] u_full;
    logic [XW-1:0] s_full;

    always_comb begin
        u_full = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
        s_full = {a[WIDTH-1], a} + {b[WIDTH-1], b} + {{WIDTH{1'b0}}, cin};
        sum    = u_full[WIDTH-1:0];
        flags.n = u_full[WIDTH-1];
        flags.z = (u_full[WIDTH-1:0] == '0);
        flags.c = u_full[WIDTH];
        flags.v = s_full[WIDTH] ^ s_full[WIDTH-1];
    end

    // R1: adding nothing returns the first operand with no carry or overflow
    p_identity_r1: assert property (@(posedge clk) disable iff (rst)
        (!cin && b == '0) |-> (sum == a && !flags.c && !flags.v));

    // R2: an all-zero result can never be negative
    p_zero_not_neg_r2: assert property (@(posedge clk) disable iff (rst)
        flags.z |-> !flags.n);

endmodule

// File: rtl/addc_flag_reg.sv
module addc_flag_reg
    import addc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   we,
    input  flags_t d,
    output flags_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= d;
    end

    // R6: flags stay put on edges without a write
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

    // R6: a write captures the adder flags present at the edge
    p_load_r6: assert property (@(posedge clk) disable iff (rst)
        we |=> q == $past(d));

    // R7: reset clears the flags
    p_clear_r7: assert property (@(posedge clk)
        rst |=> q == '0);

endmodule

// File: rtl/addc_cond_eval.sv
module addc_cond_eval
    import addc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] code,
    input  flags_t     flags,
    output logic       pass
);
    base_test_e sel;
    logic       base;

    always_comb begin
        sel  = base_test_e'(code[3:1]);
        base = base_eval(sel, flags);
        if (code[0] && code != COND_ALWAYS_ALT)
            pass = ~base;
        else
            pass = base;
    end

    // R9: both always codes pass regardless of flags
    p_always_r9: assert property (@(posedge clk) disable iff (rst)
        (code[3:1] == 3'b111) |-> pass);

    // R8: code 0000 tracks the zero flag
    p_eq_r8: assert property (@(posedge clk) disable iff (rst)
        (code == 4'b0000) |-> (pass == flags.z));

    // R9: code 0001 is the complement of the zero flag
    p_ne_r9: assert property (@(posedge clk) disable iff (rst)
        (code == 4'b0001) |-> (pass != flags.z));

endmodule

// File: rtl/addc_cond_unit.sv
module addc_cond_unit
    import addc_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    input  logic             flag_we,
    input  logic [3:0]       cond_code,
    output logic [WIDTH-1:0] sum,
    output logic [3:0]       flags_now,
    output logic [3:0]       flags_q,
    output logic             cond_pass
);
    flags_t add_flags;
    flags_t reg_flags;

    addc_adder #(.WIDTH(WIDTH)) u_adder (
        .clk   (clk),
        .rst   (rst),
        .a     (op_a),
        .b     (op_b),
        .cin   (carry_in),
        .sum   (sum),
        .flags (add_flags)
    );

    addc_flag_reg u_flags (
        .clk (clk),
        .rst (rst),
        .we  (flag_we),
        .d   (add_flags),
        .q   (reg_flags)
    );

    addc_cond_eval u_cond (
        .clk   (clk),
        .rst   (rst),
        .code  (cond_code),
        .flags (reg_flags),
        .pass  (cond_pass)
    );

    assign flags_now = add_flags;
    assign flags_q   = reg_flags;

    // R10: the condition result only moves after an edge that wrote flags
    p_pass_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (!flag_we && $stable(cond_code)) |=> $stable(cond_pass));

endmodule

// File: tb/tb_addc_cond_unit.sv
module tb_addc_cond_unit;
    localparam int W = 8;
    localparam int M = 1 << W;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] op_a, op_b;
    logic         carry_in, flag_we;
    logic [3:0]   cond_code;
    logic [W-1:0] sum;
    logic [3:0]   flags_now, flags_q;
    logic         cond_pass;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    addc_cond_unit #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
        .flag_we(flag_we), .cond_code(cond_code), .sum(sum),
        .flags_now(flags_now), .flags_q(flags_q), .cond_pass(cond_pass)
    );

    // Model of the adder flags, packed N Z C V (R5)
    function automatic logic [3:0] mdl_flags(input int a, input int b, input int c);
        int us, sa, sb, ss, res, sres;
        logic [3:0] f;
        us   = a + b + c;
        sa   = (a >= M/2) ? a - M : a;
        sb   = (b >= M/2) ? b - M : b;
        ss   = sa + sb + c;
        res  = us % M;
        sres = (res >= M/2) ? res - M : res;
        f[3] = (res >= M/2);
        f[2] = (res == 0);
        f[1] = (res != us);
        f[0] = (sres != ss);
        return f;
    endfunction

    function automatic logic mdl_cond(input logic [3:0] cc, input logic [3:0] f);
        logic n, z, c, v, r;
        {n, z, c, v} = f;
        case (cc[3:1])
            3'd0: r = z;
            3'd1: r = c;
            3'd2: r = n;
            3'd3: r = v;
            3'd4: r = c & ~z;
            3'd5: r = (n == v);
            3'd6: r = (n == v) & ~z;
            default: r = 1'b1;
        endcase
        if (cc[0] && cc != 4'hF) r = ~r;
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_flags(input int a, input int b, input int c);
        @(negedge clk);
        op_a = W'(a); op_b = W'(b); carry_in = c[0]; flag_we = 1'b1;
        @(negedge clk);
        flag_we = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1; flag_we = 1'b1; op_a = 8'hFF; op_b = 8'h01; carry_in = 1'b0; cond_code = 4'h0;
        repeat (3) @(negedge clk);
        #1;
        chk(flags_q == 4'h0, "R7 reset clears flags", flags_q, 0);
        chk(cond_pass == 1'b0, "R8 EQ false after reset", cond_pass, 0);
        cond_code = 4'h1; #1;
        chk(cond_pass == 1'b1, "R9 NE true after reset", cond_pass, 1);
        @(negedge clk);
        rst = 1'b0; flag_we = 1'b0;
    endtask

    task automatic t_adder_sweep();
        logic [3:0] ef;
        for (int a = 0; a < M; a++)
            for (int b = 0; b < M; b++)
                for (int c = 0; c < 2; c++) begin
                    op_a = W'(a); op_b = W'(b); carry_in = c[0];
                    #1;
                    ef = mdl_flags(a, b, c);
                    chk(sum == W'(a + b + c), "R1 sum", sum, W'(a + b + c));
                    chk(flags_now[3:2] == ef[3:2], "R2 N/Z", flags_now, ef);
                    chk(flags_now[1] == ef[1], "R3 carry", flags_now, ef);
                    chk(flags_now[0] == ef[0], "R4 overflow", flags_now, ef);
                end
        op_a = 8'h7F; op_b = 8'h01; carry_in = 1'b0; #1;
        chk(flags_now == 4'b1001, "R5 bit order 7F+1", flags_now, 4'b1001);
        op_a = 8'hFF; op_b = 8'h01; #1;
        chk(flags_now == 4'b0110, "R5 bit order FF+1", flags_now, 4'b0110);
    endtask

    task automatic t_subtract();
        int pairs [6][2] = '{'{5, 3}, '{3, 5}, '{0, 0}, '{128, 1}, '{255, 255}, '{0, 255}};
        for (int i = 0; i < 6; i++) begin
            op_a = W'(pairs[i][0]); op_b = ~W'(pairs[i][1]); carry_in = 1'b1; #1;
            chk(sum == W'(pairs[i][0] - pairs[i][1]), "R11 difference", sum, W'(pairs[i][0] - pairs[i][1]));
            chk(flags_now[1] == (pairs[i][0] >= pairs[i][1]), "R11 no-borrow carry", flags_now[1], pairs[i][0] >= pairs[i][1]);
        end
    endtask

    task automatic t_flag_hold();
        load_flags(8'h80, 8'h80, 0);
        chk(flags_q == 4'b0111, "R6 load on write", flags_q, 4'b0111);
        @(negedge clk);
        op_a = 8'h01; op_b = 8'h01; carry_in = 1'b0; flag_we = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk(flags_q == 4'b0111, "R6 hold without write", flags_q, 4'b0111);
        load_flags(1, 1, 0);
        chk(flags_q == 4'b0000, "R6 reload", flags_q, 0);
    endtask

    task automatic find_ops(input logic [3:0] f, output int fa, output int fb, output int fc, output bit ok);
        ok = 1'b0; fa = 0; fb = 0; fc = 0;
        for (int a = 0; a < M && !ok; a++)
            for (int b = 0; b < M && !ok; b++)
                for (int c = 0; c < 2 && !ok; c++)
                    if (mdl_flags(a, b, c) == f) begin
                        fa = a; fb = b; fc = c; ok = 1'b1;
                    end
    endtask

    task automatic t_cond_matrix();
        int a, b, c;
        bit ok;
        logic e;
        for (int f = 0; f < 16; f++) begin
            find_ops(4'(f), a, b, c, ok);
            if (ok) begin
                load_flags(a, b, c);
                chk(flags_q == 4'(f), "R6 matrix load", flags_q, f);
                for (int cc = 0; cc < 16; cc++) begin
                    cond_code = 4'(cc); #1;
                    e = mdl_cond(4'(cc), 4'(f));
                    if (cc[0] && cc != 15)
                        chk(cond_pass == e, "R9 inverted code", {cc[7:0], flags_q, 3'b0, cond_pass}, {cc[7:0], 4'(f), 3'b0, e});
                    else
                        chk(cond_pass == e, "R8 base code", {cc[7:0], flags_q, 3'b0, cond_pass}, {cc[7:0], 4'(f), 3'b0, e});
                end
            end
        end
    endtask

    task automatic t_registered_view();
        load_flags(1, 1, 0);
        cond_code = 4'h0; #1;
        chk(cond_pass == 1'b0, "R10 EQ with registered flags clear", cond_pass, 0);
        op_a = 8'h00; op_b = 8'h00; carry_in = 1'b0; flag_we = 1'b0; #1;
        chk(flags_now[2] == 1'b1, "R10 adder shows zero", flags_now, 4'b0100);
        chk(cond_pass == 1'b0, "R10 ignores adder flags", cond_pass, 0);
        @(negedge clk); flag_we = 1'b1; #1;
        chk(cond_pass == 1'b0, "R10 unchanged before write edge", cond_pass, 0);
        @(negedge clk); flag_we = 1'b0; #1;
        chk(cond_pass == 1'b1, "R10 follows after write edge", cond_pass, 1);
    endtask

    initial begin
        t_reset();
        t_adder_sweep();
        t_subtract();
        t_flag_hold();
        t_cond_matrix();
        t_registered_view();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule